// File: doc/BRIEF.md
# PLL Power-Up Lock Sequencer

This block brings the reference PLL of a frequency synthesizer up and down in a fixed order. An enable request runs these steps:
- take the PLL out of soft reset;
- set the input-noise bandwidth filter to the code for a good reference;
- load the feedback divider;
- remove power-down;
- wait for the PLL to report lock.

The wait is bounded by a cycle counter. The request ends either with a one-cycle done pulse or with a timeout flag. The flag stays set until the next request is accepted. A disable request powers the PLL down first and only then puts it back into soft reset, and it ends with a done pulse.

Each step takes one clock cycle. The power-down control has a configurable active level, and the enabled status is read back from that control. The block also outputs the feedback multiplication factor, which is the divider field plus 16. The analog PLL is outside the block and returns only its lock indication.

Top module: `pll_pwr_seq`

## Requirements
- R1: While reset is held and after it is released, the outputs are as follows: the PLL soft reset is asserted (`pll_rst_no`=0), `pwr_dn_o` equals `PD_POL`, `bw_sel_o` equals `BW_RESET`, `fb_div_o`=0, and `enabled_o`, `done_o` and `timeout_o` are all 0.
- R2: On an accepted enable request, the steps change the outputs in cycles after the accept edge as follows: soft reset is released 1 cycle after, the bandwidth code is written 2 cycles after, the divider 3 cycles after, and power-down is removed 4 cycles after.
- R3: The enable sequence always writes bandwidth code 0, the good-reference code out of the codes 0 to 3.
- R4: Powering up drives `pwr_dn_o` to the inverse of `PD_POL`, and powering down drives it to `PD_POL`.
- R5: In the lock wait, the first edge that samples `lock_i` high ends the sequence, and `done_o` is high for exactly the following cycle.
- R6: If `lock_i` is not seen within `TIMEOUT_CYC` edges of the lock wait, `timeout_o` rises on the last of those edges and `done_o` stays low. `timeout_o` then holds until the edge that accepts the next request, which clears it.
- R7: On an accepted disable request, power-down is applied 1 cycle after the accept edge. Soft reset is asserted 2 cycles after, and `done_o` is high in that same cycle.
- R8: `fb_mult_o` always equals `fb_div_o` + 16.
- R9: `enabled_o` is 1 exactly when `pwr_dn_o` differs from `PD_POL`.
- R10: A request (`req_valid_i`=1) that arrives while a sequence is running has no effect on any output.
- R11: The divider loaded by an enable sequence is the value of `div_i` on the accept edge. Later changes to `div_i` are not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe; accepted only when idle |
| req_on_i | input | 1 | 1 requests enable, 0 requests disable |
| div_i | input | DIV_W | Feedback divider field for the enable sequence |
| lock_i | input | 1 | Lock indication from the PLL |
| pll_rst_no | output | 1 | PLL soft reset, active low |
| bw_sel_o | output | 2 | Reference bandwidth filter code |
| fb_div_o | output | DIV_W | Loaded feedback divider field |
| fb_mult_o | output | MULT_W | Feedback multiplication factor (field + 16) |
| pwr_dn_o | output | 1 | PLL power-down control; active level `PD_POL` |
| enabled_o | output | 1 | PLL is powered, as read back from `pwr_dn_o` |
| done_o | output | 1 | One-cycle pulse when a sequence completes |
| timeout_o | output | 1 | Lock wait expired; held until the next accepted request |

## Verification
The request is driven on a falling edge, so the rising edge that follows is the accept edge and gets the index 0. Each output is then due at a fixed count of registers after that edge: soft-reset release at 1, bandwidth at 2, divider at 3, power-up at 4, done one cycle after lock is sampled, timeout `TIMEOUT_CYC` edges after power-up, and power-down and soft reset at 1 and 2 for a disable. The bench checks every output on every falling edge in between. At each of these samples it compares the complete output set against a model that changes one field per step. This catches a field that moves too early as well as one that moves too late. Two instances run side by side, one for each power-down polarity, over all divider values, several lock delays, requests injected during a running sequence, and a lock that never arrives.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_EN_RST, ST_EN_BW, ST_EN_DIV, ST_EN_PWR, ST_WAIT, ST_DIS_PD, ST_DIS_RST
  } seq_st_e;
  localparam logic [1:0] BW_GOOD  = 2'd0;
  localparam int         MULT_OFS = 16;
endpackage

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int TIMEOUT_CYC = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (cnt_q != LAST)    cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  // the sequencer must leave the wait as soon as the window runs out
  assert_expire_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int         DIV_W    = 3,
  parameter bit         PD_POL   = 1'b1,
  parameter logic [1:0] BW_RESET = 2'd3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_on_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             lock_i,
  input  logic             expire_i,
  output logic             wait_o,
  output logic             pll_rst_no,
  output logic [1:0]       bw_sel_o,
  output logic [DIV_W-1:0] fb_div_o,
  output logic             pwr_dn_o,
  output logic             done_o,
  output logic             timeout_o
);
  seq_st_e          st_q;
  logic [DIV_W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      pend_q     <= '0;
      pll_rst_no <= 1'b0;
      bw_sel_o   <= BW_RESET;
      fb_div_o   <= '0;
      pwr_dn_o   <= PD_POL;
      done_o     <= 1'b0;
      timeout_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          timeout_o <= 1'b0;
          pend_q    <= div_i;
          st_q      <= req_on_i ? ST_EN_RST : ST_DIS_PD;
        end
        ST_EN_RST: begin pll_rst_no <= 1'b1;    st_q <= ST_EN_BW;  end
        ST_EN_BW:  begin bw_sel_o   <= BW_GOOD; st_q <= ST_EN_DIV; end
        ST_EN_DIV: begin fb_div_o   <= pend_q;  st_q <= ST_EN_PWR; end
        ST_EN_PWR: begin pwr_dn_o   <= ~PD_POL; st_q <= ST_WAIT;   end
        ST_WAIT: begin
          if (lock_i) begin
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (expire_i) begin
            timeout_o <= 1'b1;
            st_q      <= ST_IDLE;
          end
        end
        ST_DIS_PD:  begin pwr_dn_o <= PD_POL; st_q <= ST_DIS_RST; end
        ST_DIS_RST: begin
          pll_rst_no <= 1'b0;
          done_o     <= 1'b1;
          st_q       <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wait_o = (st_q == ST_WAIT);

  assert_pwr_needs_rst_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_dn_o != PD_POL) |-> pll_rst_no);
  assert_bw_good_in_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> (bw_sel_o == BW_GOOD));
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_no_done_with_timeout_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));
  assert_busy_holds_divider_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> $stable(pend_q));
endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pll_seq_pkg::*;
#(
  parameter int         DIV_W       = 3,
  parameter int         TIMEOUT_CYC = 2_000_000,
  parameter bit         PD_POL      = 1'b1,
  parameter logic [1:0] BW_RESET    = 2'd3,
  localparam int        MULT_W      = $clog2((1 << DIV_W) + MULT_OFS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_on_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              lock_i,
  output logic              pll_rst_no,
  output logic [1:0]        bw_sel_o,
  output logic [DIV_W-1:0]  fb_div_o,
  output logic [MULT_W-1:0] fb_mult_o,
  output logic              pwr_dn_o,
  output logic              enabled_o,
  output logic              done_o,
  output logic              timeout_o
);
  logic wait_w, expire_w;

  pll_seq_ctrl #(.DIV_W(DIV_W), .PD_POL(PD_POL), .BW_RESET(BW_RESET)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_on_i, .div_i, .lock_i,
    .expire_i(expire_w), .wait_o(wait_w), .pll_rst_no, .bw_sel_o,
    .fb_div_o, .pwr_dn_o, .done_o, .timeout_o
  );

  pll_lock_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i, .rst_ni, .run_i(wait_w), .expire_o(expire_w)
  );

  assign fb_mult_o = MULT_W'(fb_div_o) + MULT_W'(MULT_OFS);
  assign enabled_o = (pwr_dn_o != PD_POL);

  assert_enabled_after_seq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && enabled_o) |-> (fb_mult_o >= MULT_W'(MULT_OFS)));
endmodule

// File: tb/tb_pll_pwr_seq.sv
`timescale 1ns/1ps
module tb_pll_pwr_seq;
  localparam int DIV_W = 3;
  localparam int TMO   = 12;
  localparam int MW    = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_on = 1'b0, lock = 1'b0;
  logic [DIV_W-1:0] div = '0;

  logic srn_h, pd_h, en_h, dn_h, to_h, srn_l, pd_l, en_l, dn_l, to_l;
  logic [1:0] bw_h, bw_l;
  logic [DIV_W-1:0] fd_h, fd_l;
  logic [MW-1:0] fm_h, fm_l;

  int checks = 0, fails = 0;
  int e_srn = 0, e_bw = 3, e_div = 0, e_pwr = 0, e_to = 0;

  always #2.5 clk = ~clk;

  pll_pwr_seq #(.DIV_W(DIV_W), .TIMEOUT_CYC(TMO), .PD_POL(1'b1), .BW_RESET(2'd3)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_on_i(req_on), .div_i(div),
    .lock_i(lock), .pll_rst_no(srn_h), .bw_sel_o(bw_h), .fb_div_o(fd_h), .fb_mult_o(fm_h),
    .pwr_dn_o(pd_h), .enabled_o(en_h), .done_o(dn_h), .timeout_o(to_h));

  pll_pwr_seq #(.DIV_W(DIV_W), .TIMEOUT_CYC(TMO), .PD_POL(1'b0), .BW_RESET(2'd3)) dut_lo (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_on_i(req_on), .div_i(div),
    .lock_i(lock), .pll_rst_no(srn_l), .bw_sel_o(bw_l), .fb_div_o(fd_l), .fb_mult_o(fm_l),
    .pwr_dn_o(pd_l), .enabled_o(en_l), .done_o(dn_l), .timeout_o(to_l));

  task automatic cmp(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", r, what, $time, act, exp);
    end
  endtask

  // checks every output of both polarity variants against the step model
  task automatic expect_all(string r, int dn);
    cmp(r, "rst_n hi", srn_h, e_srn);  cmp(r, "rst_n lo", srn_l, e_srn);
    cmp(r, "bw hi", bw_h, e_bw);       cmp(r, "bw lo", bw_l, e_bw);
    cmp(r, "div hi", fd_h, e_div);     cmp(r, "div lo", fd_l, e_div);
    cmp("R8", "mult hi", fm_h, e_div + 16); cmp("R8", "mult lo", fm_l, e_div + 16);
    cmp("R4", "pd pol1", pd_h, e_pwr ? 0 : 1);
    cmp("R4", "pd pol0", pd_l, e_pwr ? 1 : 0);
    cmp("R9", "en hi", en_h, e_pwr);   cmp("R9", "en lo", en_l, e_pwr);
    cmp(r, "done hi", dn_h, dn);       cmp(r, "done lo", dn_l, dn);
    cmp(r, "tmo hi", to_h, e_to);      cmp(r, "tmo lo", to_l, e_to);
  endtask

  task automatic do_enable(int d, int ldly, bit never, bit poke);
    @(negedge clk); req_valid = 1'b1; req_on = 1'b1; div = DIV_W'(d);
    @(negedge clk); req_valid = 1'b0; div = DIV_W'(d ^ 7);   // R11: later changes unused
    e_to = 0; expect_all("R6", 0);
    if (poke) begin req_valid = 1'b1; req_on = 1'b0; end      // R10: ignored while busy
    @(negedge clk); e_srn = 1; expect_all("R2", 0);
    @(negedge clk); req_valid = 1'b0; e_bw = 0; expect_all("R3", 0);
    @(negedge clk); e_div = d; expect_all("R11", 0);
    if (poke) begin req_valid = 1'b1; req_on = 1'b0; end
    @(negedge clk); req_valid = 1'b0; e_pwr = 1; expect_all("R2", 0);
    if (never) begin
      for (int i = 0; i < TMO - 1; i++) begin @(negedge clk); expect_all("R6", 0); end
      @(negedge clk); e_to = 1; expect_all("R6", 0);
    end else begin
      for (int i = 0; i < ldly; i++) begin @(negedge clk); expect_all("R5", 0); end
      lock = 1'b1;
      @(negedge clk); expect_all("R5", 1);
      @(negedge clk); expect_all("R5", 0);
    end
  endtask

  task automatic do_disable(bit poke);
    @(negedge clk); req_valid = 1'b1; req_on = 1'b0;
    @(negedge clk); req_valid = 1'b0; e_to = 0; expect_all("R6", 0);
    @(negedge clk); e_pwr = 0; lock = 1'b0; expect_all("R7", 0);
    if (poke) begin req_valid = 1'b1; req_on = 1'b1; end
    @(negedge clk); req_valid = 1'b0; e_srn = 0; expect_all("R7", 1);
    @(negedge clk); expect_all("R10", 0);
    for (int i = 0; i < 3; i++) begin @(negedge clk); expect_all("R10", 0); end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    repeat (2) @(negedge clk);
    expect_all("R1", 0);
    rst_n = 1'b1;
    @(negedge clk); expect_all("R1", 0);
    for (int d = 0; d < 8; d++) begin
      do_enable(d, d % 4, 1'b0, d[0]);
      do_disable(d[1]);
    end
    do_enable(6, 2, 1'b0, 1'b0);
    do_enable(1, 0, 1'b0, 1'b1);       // enable while already enabled
    do_disable(1'b0);
    do_enable(5, 0, 1'b1, 1'b1);       // lock never arrives
    for (int i = 0; i < 4; i++) begin @(negedge clk); expect_all("R6", 0); end
    do_disable(1'b0);
    do_enable(3, 1, 1'b0, 1'b0);
    report();
  end
endmodule